// File: doc/BRIEF.md
# USB Transmit Serializer with Bit Stuffing and NRZI

This block is the transmit half of a USB 2.0 transceiver cell. A serial interface engine hands it bytes over an 8-bit bus with a valid/ready handshake. Each byte waits in a single holding register until the serializer needs it. The serializer sends SYNC, then the bytes least significant bit first, inserting a stuffed zero after every run of six ones. The stream is NRZI-encoded onto a D+/D- pair with an output enable. The packet is closed with an end-of-packet sequence.

The level of `tx_valid` alone frames a packet. A rising level starts SYNC. When the holding register is empty at a byte boundary, the packet ends and EOP follows. One bit time equals one clock. In full-speed mode SYNC starts at once. In high-speed mode SYNC starts after a fixed wait of `HS_WAIT` bit times. A two-bit mode input selects one of three behaviours: normal transmission, a non-driving state in which requests are ignored, or raw transmission with stuffing and NRZI bypassed. The mode is captured when a packet starts.

Top module: `usbtx_xmit`

## Requirements
- R1: A byte on `tx_data` is captured into the holding register at a rising edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while idle and while the holding register is full.
- R2: Let edge k be the first edge that samples `tx_valid` high while idle. With `hs_sel`=0, `line_oe` rises and the first SYNC bit is driven after edge k+1. With `hs_sel`=1 this happens after edge k+HS_WAIT+1. The default HS_WAIT of 9 gives 10 bit times, which lies inside the 8 to 16 window.
- R3: Before encoding, SYNC is seven zeros followed by a one. Data bytes follow least significant bit first, in the order they were handed in.
- R4: In normal mode (`opmode`=00), NRZI starts from J (`line_dp`=1, `line_dm`=0). A 0 toggles the pair, and a 1 keeps it.
- R5: In normal mode, a 0 is inserted after every six consecutive 1s in the pre-encoding stream. This also applies when the run completes on the packet's final bit, in which case the stuffed 0 comes before EOP.
- R6: After the last bit, the lines show two bit times of SE0 (both low), then one bit time of J with `line_oe` high. `line_oe` is low in the following cycle.
- R7: With `opmode`=10, no bits are stuffed and NRZI is bypassed. The line carries each bit directly (1 = J, 0 = K). EOP is unchanged.
- R8: With `opmode`=01 or 11 while idle, `tx_valid` is ignored, and `line_oe` and `tx_ready` stay low.
- R9: A packet ends when the holding register is empty at a byte boundary. A one-cycle `tx_valid` pulse sends SYNC and EOP only. When idle, `line_oe` is low and the lines rest at J.
- R10: After reset, `line_oe`=0, `tx_ready`=0, `line_dp`=1 and `line_dm`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte from the interface engine |
| tx_valid | input | 1 | Packet framing level and byte valid |
| tx_ready | output | 1 | Holding register can take a byte |
| opmode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 treated as 01 |
| hs_sel | input | 1 | 1 selects the high-speed start wait |
| line_dp | output | 1 | D+ level |
| line_dm | output | 1 | D- level |
| line_oe | output | 1 | Line driver enable |

## Verification
The in-RTL assertions check the following every cycle:
- a handshake always fills the holding register, and ready never coexists with a full register;
- in full-speed mode, detecting a request leads directly to SYNC;
- a non-driving idle state stays idle;
- the stuffing run counter never passes six;
- every EOP has exactly two SE0 bit times, then J, then release.

Other properties can only be shown by the bench, which decodes the whole bus waveform back into bytes:
- the SYNC pattern and the byte order;
- the NRZI polarity and the position of stuffed bits, including a stuffed bit that falls just before EOP;
- the raw mode bypass;
- the measured start latency in both speed modes.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'b00,
    OPM_NODRIVE = 2'b01,
    OPM_RAW     = 2'b10,
    OPM_RSVD    = 2'b11
  } opmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SYNC,
    ST_DATA,
    ST_EOP1,
    ST_EOP2,
    ST_EOPJ
  } tx_state_e;

  // One command per bit time towards the line stage
  typedef struct packed {
    logic bit_vld;
    logic bit_val;
    logic se0;
    logic j_end;
  } line_cmd_t;

endpackage

// File: rtl/usbtx_hold.sv
module usbtx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              active_nx,
  input  logic              take,
  output logic              tx_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);

  logic              full_q;
  logic              rdy_q;
  logic [DATA_W-1:0] data_q;
  logic              load;
  logic              full_nx;

  assign load    = tx_valid && rdy_q;
  assign full_nx = load || (full_q && !take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_nx;
      rdy_q  <= active_nx && !full_nx;
      if (load) data_q <= tx_data;
    end
  end

  assign tx_ready  = rdy_q;
  assign hold_full = full_q;
  assign hold_data = data_q;

  // R1: a handshake always leaves the register holding a byte
  assert_load_fills_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && rdy_q) |=> full_q);

  // R1: ready is never offered while a byte is already held
  assert_ready_empty_R1: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> !full_q);

endmodule

// File: rtl/usbtx_ctrl.sv
module usbtx_ctrl
  import usbtx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HS_WAIT   = 9,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [1:0]        opmode,
  input  logic              hs_sel,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              active_nx,
  output logic              nrzi_en,
  output line_cmd_t         cmd
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int WAIT_W = $clog2(HS_WAIT + 1);
  localparam logic [DATA_W-1:0] SYNC_PAT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DATA_W - 1);

  tx_state_e         state_q, state_nx;
  logic              raw_q, raw_nx;
  logic              drain_q, drain_nx;
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [IDX_W-1:0]  idx_q, idx_nx;
  logic [RUN_W-1:0]  ones_q, ones_nx;
  logic [WAIT_W-1:0] wait_q, wait_nx;

  logic stuff_en, in_bits, stuff_now, emit_bit;

  assign stuff_en  = !raw_q;
  assign in_bits   = (state_q == ST_SYNC) || (state_q == ST_DATA);
  assign stuff_now = stuff_en && in_bits && (ones_q == RUN_W'(STUFF_RUN));
  assign emit_bit  = stuff_now ? 1'b0 : sh_q[0];

  always_comb begin
    state_nx = state_q;
    raw_nx   = raw_q;
    drain_nx = drain_q;
    sh_nx    = sh_q;
    idx_nx   = idx_q;
    ones_nx  = ones_q;
    wait_nx  = wait_q;
    take     = 1'b0;
    cmd      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_valid && !opmode[0]) begin
          raw_nx   = opmode[1];
          sh_nx    = SYNC_PAT;
          idx_nx   = '0;
          ones_nx  = '0;
          drain_nx = 1'b0;
          wait_nx  = WAIT_W'(HS_WAIT);
          state_nx = hs_sel ? ST_WAIT : ST_SYNC;
        end
      end
      ST_WAIT: begin
        if (wait_q <= WAIT_W'(1)) state_nx = ST_SYNC;
        else                      wait_nx  = wait_q - WAIT_W'(1);
      end
      ST_SYNC, ST_DATA: begin
        cmd.bit_vld = 1'b1;
        cmd.bit_val = emit_bit;
        ones_nx = (emit_bit && stuff_en) ? ones_q + RUN_W'(1) : '0;
        if (drain_q) begin
          drain_nx = 1'b0;
          state_nx = ST_EOP1;
        end else if (!stuff_now) begin
          sh_nx  = sh_q >> 1;
          idx_nx = idx_q + IDX_W'(1);
          if (idx_q == IDX_LAST) begin
            if (hold_full) begin
              take     = 1'b1;
              sh_nx    = hold_data;
              idx_nx   = '0;
              state_nx = ST_DATA;
            end else if (stuff_en && ones_nx == RUN_W'(STUFF_RUN)) begin
              drain_nx = 1'b1;
            end else begin
              state_nx = ST_EOP1;
            end
          end
        end
      end
      ST_EOP1: begin
        cmd.se0  = 1'b1;
        state_nx = ST_EOP2;
      end
      ST_EOP2: begin
        cmd.se0  = 1'b1;
        state_nx = ST_EOPJ;
      end
      ST_EOPJ: begin
        cmd.j_end = 1'b1;
        state_nx  = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  assign active_nx = ((state_nx == ST_WAIT) || (state_nx == ST_SYNC) ||
                      (state_nx == ST_DATA)) && !drain_nx;
  assign nrzi_en   = !raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      raw_q   <= 1'b0;
      drain_q <= 1'b0;
      sh_q    <= '0;
      idx_q   <= '0;
      ones_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_nx;
      raw_q   <= raw_nx;
      drain_q <= drain_nx;
      sh_q    <= sh_nx;
      idx_q   <= idx_nx;
      ones_q  <= ones_nx;
      wait_q  <= wait_nx;
    end
  end

  // R2: full-speed request goes straight to SYNC on the next edge
  assert_fs_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && tx_valid && !opmode[0] && !hs_sel) |=> (state_q == ST_SYNC));

  // R8: a non-driving or reserved mode keeps the machine idle
  assert_nodrive_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && opmode[0]) |=> (state_q == ST_IDLE));

  // R5: the run of ones never grows past the stuffing limit
  assert_stuff_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (stuff_en && in_bits) |-> (ones_q <= RUN_W'(STUFF_RUN)));

endmodule

// File: rtl/usbtx_line.sv
module usbtx_line
  import usbtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_cmd_t cmd,
  input  logic      nrzi_en,
  output logic      line_dp,
  output logic      line_dm,
  output logic      line_oe
);

  logic lvl_q, lvl_nx;
  logic dp_q, dm_q, oe_q;
  logic dp_nx, dm_nx, oe_nx;
  logic se0_out;

  always_comb begin
    lvl_nx = 1'b1;
    dp_nx  = 1'b1;
    dm_nx  = 1'b0;
    oe_nx  = 1'b0;
    if (cmd.bit_vld) begin
      lvl_nx = nrzi_en ? (cmd.bit_val ? lvl_q : !lvl_q) : cmd.bit_val;
      dp_nx  = lvl_nx;
      dm_nx  = !lvl_nx;
      oe_nx  = 1'b1;
    end else if (cmd.se0) begin
      dp_nx = 1'b0;
      dm_nx = 1'b0;
      oe_nx = 1'b1;
    end else if (cmd.j_end) begin
      oe_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      dp_q  <= 1'b1;
      dm_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_nx;
      dp_q  <= dp_nx;
      dm_q  <= dm_nx;
      oe_q  <= oe_nx;
    end
  end

  assign line_dp = dp_q;
  assign line_dm = dm_q;
  assign line_oe = oe_q;
  assign se0_out = oe_q && !dp_q && !dm_q;

  // R6: SE0 never lasts a single bit time
  assert_eop_two_R6: assert property (@(posedge clk) disable iff (rst)
    (se0_out && !$past(se0_out)) |=> se0_out);

  // R6: the second SE0 bit time is followed by a driven J
  assert_eop_j_R6: assert property (@(posedge clk) disable iff (rst)
    (se0_out && $past(se0_out)) |=> (oe_q && dp_q && !dm_q));

  // R6: the driver is released right after the closing J
  assert_eop_release_R6: assert property (@(posedge clk) disable iff (rst)
    (oe_q && dp_q && !dm_q && $past(se0_out)) |=> !oe_q);

endmodule

// File: rtl/usbtx_xmit.sv
module usbtx_xmit
  import usbtx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HS_WAIT   = 9,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [1:0]        opmode,
  input  logic              hs_sel,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe
);

  logic              take;
  logic              active_nx;
  logic              nrzi_en;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  line_cmd_t         cmd;

  usbtx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .active_nx (active_nx),
    .take      (take),
    .tx_ready  (tx_ready),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  usbtx_ctrl #(
    .DATA_W    (DATA_W),
    .HS_WAIT   (HS_WAIT),
    .STUFF_RUN (STUFF_RUN)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .opmode    (opmode),
    .hs_sel    (hs_sel),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .active_nx (active_nx),
    .nrzi_en   (nrzi_en),
    .cmd       (cmd)
  );

  usbtx_line line_i (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .nrzi_en (nrzi_en),
    .line_dp (line_dp),
    .line_dm (line_dm),
    .line_oe (line_oe)
  );

endmodule

// File: tb/usbtx_xmit_tb_top.sv
module usbtx_xmit_tb_top;

  localparam int HS_WAIT = 9;
  localparam int MAXB    = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic [1:0] opmode = 2'b00;
  logic       hs_sel = 1'b0;
  logic       tx_ready, line_dp, line_dm, line_oe;

  always #5 clk = ~clk;

  usbtx_xmit #(.DATA_W(8), .HS_WAIT(HS_WAIT), .STUFF_RUN(6)) dut_i (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .opmode(opmode), .hs_sel(hs_sel),
    .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Line monitor: records line levels of one packet
  int  pkt_seq = 0;
  int  seen_seq = 0;
  bit  lv_buf [0:4095];
  int  nlv = 0;
  int  se0_n = 0;
  bit  pkt_done = 1'b0;
  bit  eop_j_ok = 1'b0;
  bit  oe_seen = 1'b0;
  time t_oe = 0;
  time t_val = 0;

  always @(negedge clk) begin
    if (seen_seq != pkt_seq) begin
      seen_seq = pkt_seq;
      nlv = 0; se0_n = 0; pkt_done = 1'b0; eop_j_ok = 1'b0; oe_seen = 1'b0;
    end
    if (!rst && line_oe && !pkt_done) begin
      if (!oe_seen) begin oe_seen = 1'b1; t_oe = $time; end
      if (!line_dp && !line_dm) se0_n++;
      else if (se0_n > 0) begin pkt_done = 1'b1; eop_j_ok = line_dp && !line_dm; end
      else if (nlv < 4096) begin lv_buf[nlv] = line_dp; nlv++; end
    end
  end

  logic [7:0] pkt [0:MAXB-1];
  bit dec [0:4095];

  task automatic send(int n, bit raw, bit hs, string tag);
    int idx;
    bit rdy;
    int prev, ones, nd, stuff_err, syncv, bad_bytes, lat, exp_lat;
    @(negedge clk);
    opmode = raw ? 2'b10 : 2'b00;
    hs_sel = hs;
    pkt_seq++;
    tx_valid = 1'b1;
    tx_data = (n > 0) ? pkt[0] : 8'h00;
    t_val = $time;
    idx = 0;
    if (n == 0) @(negedge clk);
    while (idx < n) begin
      rdy = tx_ready;
      @(negedge clk);
      if (rdy) begin
        idx++;
        if (idx < n) tx_data = pkt[idx];
      end
    end
    tx_valid = 1'b0;
    wait (seen_seq == pkt_seq && pkt_done);
    @(negedge clk);
    chk(!line_oe, {"R6 release ", tag}, int'(line_oe), 0);
    chk(se0_n == 2 && eop_j_ok, {"R6 eop shape ", tag}, se0_n, 2);
    lat = int'((t_oe - t_val) / 10);
    exp_lat = hs ? HS_WAIT + 2 : 2;
    chk(lat == exp_lat, {"R2 start latency ", tag}, lat, exp_lat);
    // undo NRZI and stuffing
    prev = 1; ones = 0; nd = 0; stuff_err = 0;
    for (int i = 0; i < nlv; i++) begin
      int b;
      b = raw ? int'(lv_buf[i]) : ((int'(lv_buf[i]) == prev) ? 1 : 0);
      prev = int'(lv_buf[i]);
      if (!raw && ones == 6) begin
        if (b != 0) stuff_err++;
        ones = 0;
      end else begin
        ones = (b != 0) ? ones + 1 : 0;
        dec[nd] = (b != 0);
        nd++;
      end
    end
    if (!raw && ones == 6) stuff_err++;
    if (!raw) chk(stuff_err == 0, {"R5 stuffing ", tag}, stuff_err, 0);
    syncv = 0;
    for (int i = 0; i < 8 && i < nd; i++) syncv |= int'(dec[i]) << i;
    chk(syncv == 8'h80, {"R3 sync ", tag}, syncv, 8'h80);
    chk(nd == 8 + 8 * n, {"R9 bit count ", tag}, nd, 8 + 8 * n);
    bad_bytes = 0;
    for (int k = 0; k < n; k++) begin
      int v;
      v = 0;
      for (int j = 0; j < 8; j++)
        if (8 + 8 * k + j < nd) v |= int'(dec[8 + 8 * k + j]) << j;
      if (v != int'(pkt[k])) bad_bytes++;
    end
    if (raw) chk(bad_bytes == 0, {"R7 raw bytes ", tag}, bad_bytes, 0);
    else     chk(bad_bytes == 0, {"R4 decoded bytes R1 ", tag}, bad_bytes, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic nodrive(logic [1:0] mode, string tag);
    int bad;
    bad = 0;
    @(negedge clk);
    opmode = mode;
    tx_valid = 1'b1;
    tx_data = 8'hA5;
    repeat (14) begin
      @(negedge clk);
      if (line_oe || tx_ready) bad++;
    end
    tx_valid = 1'b0;
    @(negedge clk);
    opmode = 2'b00;
    chk(bad == 0, {"R8 ignored ", tag}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state and R9 idle lines
    chk(!line_oe && !tx_ready, "R10 reset oe/ready", int'({line_oe, tx_ready}), 0);
    chk(line_dp && !line_dm, "R10 reset J level", int'({line_dp, line_dm}), 2);

    send(0, 1'b0, 1'b0, "empty");
    pkt[0] = 8'hA5;
    send(1, 1'b0, 1'b0, "single");
    for (int i = 0; i < 4; i++) pkt[i] = 8'hFF;
    send(4, 1'b0, 1'b0, "ones");
    pkt[0] = 8'h00; pkt[1] = 8'hFC;
    send(2, 1'b0, 1'b0, "tail stuff R5");
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h00;
    send(3, 1'b1, 1'b0, "raw R7");
    pkt[0] = 8'h3C; pkt[1] = 8'h7E; pkt[2] = 8'h01;
    send(3, 1'b0, 1'b1, "hs");
    nodrive(2'b01, "mode01");
    nodrive(2'b11, "mode11");
    pkt[0] = 8'h5A;
    send(1, 1'b0, 1'b0, "after nodrive");

    for (int p = 0; p < 25; p++) begin
      int n;
      bit heavy;
      n = $urandom_range(0, 16);
      heavy = $urandom_range(0, 1);
      for (int i = 0; i < n; i++)
        pkt[i] = heavy ? (8'hFF ^ (8'h01 << $urandom_range(0, 7)) | 8'(($urandom_range(0, 1)) * 8'h01))
                       : 8'($urandom_range(0, 255));
      send(n, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), "random");
    end

    report();
    $finish;
  end

endmodule